// File: doc/BRIEF.md
# Big-Endian Sub-Word Load/Store Aligner

This block sits between a 32-bit register datapath and a word-wide, byte-addressed data memory. It takes a load or store request with a base register value and a 16-bit signed byte offset, and forms the effective address from them. For stores it places the low byte, halfword or whole word of the source register into the correct memory byte lanes and raises the matching byte-write enables. For loads it picks the addressed byte or halfword out of the returned memory word and extends it to 32 bits, with sign or zero fill. Lane mapping is big-endian: the lowest byte address of a word is its most significant byte.

Requests enter on a valid/ready handshake. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. The memory strobes for that request are driven in the acceptance cycle. The result appears one cycle later on the response port. The response is held until `rsp_ready` is seen high. While a response waits, `req_ready` stays low, so back-pressure on the response side stalls new requests. Accesses that are misaligned or that use an undefined size code are answered with an error flag and never reach the memory.

Top module: `mem_lane_aligner`

## Requirements
- R1: The memory address is `req_base` plus `req_offset` sign-extended to 32 bits, wrapping modulo 2^32.
- R2: A word access (size code 000) whose address has either of its two low bits set produces an error response and drives neither `mem_rd` nor `mem_we`.
- R3: A halfword access whose address is odd produces an error response with no memory strobe. So does any size code other than 000, 001, 010, 011 and 100.
- R4: Loads use big-endian lanes. Byte offset 0 reads bits [31:24] and offset 3 reads bits [7:0]. A halfword at offset 0 reads bits [31:16] and one at offset 2 reads bits [15:0]. A word load (000) returns the whole word.
- R5: A signed halfword load (001) or signed byte load (011) copies the top bit of the loaded item into all higher bits of the 32-bit result.
- R6: An unsigned halfword load (010) or unsigned byte load (100) fills all higher bits of the result with zero.
- R7: A byte store copies bits [7:0] of `req_wdata` into all four lanes of `mem_wdata`. It sets `mem_be` to 4'b1000 shifted right by the byte offset, where `mem_be[3]` enables bits [31:24].
- R8: A halfword store copies bits [15:0] of `req_wdata` into both halves of `mem_wdata`. It sets `mem_be` to 4'b1100 at offset 0 and to 4'b0011 at offset 2.
- R9: A word store drives `req_wdata` unchanged with `mem_be` = 4'b1111.
- R10: `rsp_valid` rises on the cycle after acceptance. A load returns its extended value. Stores and faulty requests return zero data. `rsp_err` is high exactly for faulty requests.
- R11: While `rsp_valid` is high and `rsp_ready` is low, the response data and error stay constant and `req_ready` is low. At all other times `req_ready` is high.
- R12: During and right after reset, `rsp_valid`, `mem_rd` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 3 | Size/signedness code (see R3–R6) |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed byte offset |
| req_wdata | input | 32 | Store source register value |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_data | output | 32 | Extended load result, zero for stores and errors |
| rsp_err | output | 1 | Alignment or size-code error |
| mem_addr | output | 32 | Effective byte address |
| mem_rd | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | 4 | Byte-write enables, bit 3 = bits [31:24] |
| mem_wdata | output | 32 | Lane-aligned store data |
| mem_rdata | input | 32 | Read word, valid the cycle after `mem_rd` |

## Verification
The assertions and the response-hold behaviour rely on `mem_rdata` coming from a synchronous memory. That memory must return the addressed word on the edge after `mem_rd` and must keep it unchanged until the next read strobe. The held load result is recomputed from that word while a response waits. The bench memory model only updates its read register on a read strobe. Because `req_ready` is low during a stall, no new read can start while a response is pending. The stimulus holds request fields steady from just after one rising edge until the edge where the request is accepted. It only changes `rsp_ready` at that same point in the cycle.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

  // request size/signedness codes
  typedef enum logic [2:0] {
    SZ_WORD   = 3'b000,
    SZ_HALF_S = 3'b001,
    SZ_HALF_U = 3'b010,
    SZ_BYTE_S = 3'b011,
    SZ_BYTE_U = 3'b100
  } acc_size_e;

  typedef enum logic [1:0] {
    W_BYTE = 2'd0,
    W_HALF = 2'd1,
    W_WORD = 2'd2,
    W_BAD  = 2'd3
  } acc_width_e;

  typedef struct packed {
    acc_width_e width;
    logic       sext;
  } acc_kind_t;

  // context kept between acceptance and response
  typedef struct packed {
    logic      is_load;
    logic      fault;
    acc_kind_t kind;
  } rsp_ctx_t;

  function automatic acc_kind_t decode_size(input logic [2:0] code);
    acc_kind_t k;
    unique case (code)
      SZ_WORD:   k = '{width: W_WORD, sext: 1'b0};
      SZ_HALF_S: k = '{width: W_HALF, sext: 1'b1};
      SZ_HALF_U: k = '{width: W_HALF, sext: 1'b0};
      SZ_BYTE_S: k = '{width: W_BYTE, sext: 1'b1};
      SZ_BYTE_U: k = '{width: W_BYTE, sext: 1'b0};
      default:   k = '{width: W_BAD,  sext: 1'b0};
    endcase
    return k;
  endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 16,
  parameter int LANE_BITS = 2
) (
  input  logic [ADDR_W-1:0]    base,
  input  logic [OFF_W-1:0]     offset,
  input  logic [2:0]           size_code,
  output logic [ADDR_W-1:0]    eff_addr,
  output acc_kind_t            kind,
  output logic [LANE_BITS-1:0] lane_off,
  output logic                 misalign,
  output logic                 bad_code
);
  localparam int EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] off_ext;

  assign off_ext  = {{EXT_W{offset[OFF_W-1]}}, offset};
  assign eff_addr = base + off_ext;
  assign kind     = decode_size(size_code);
  assign lane_off = eff_addr[LANE_BITS-1:0];
  assign bad_code = (kind.width == W_BAD);

  always_comb begin
    unique case (kind.width)
      W_WORD:  misalign = |eff_addr[LANE_BITS-1:0];
      W_HALF:  misalign = eff_addr[0];
      default: misalign = 1'b0;
    endcase
  end

endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  acc_width_e                          width,
  input  logic [$clog2(DATA_W/8)-1:0]         lane_off,
  input  logic [DATA_W-1:0]                   src,
  output logic [DATA_W/8-1:0]                 be,
  output logic [DATA_W-1:0]                   wdata
);
  localparam int LANES     = DATA_W / 8;
  localparam int LANE_BITS = $clog2(LANES);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    // lane i holds the byte at offset K inside the word
    localparam int K = LANES - 1 - i;
    logic       lane_en;
    logic [7:0] lane_d;

    always_comb begin
      unique case (width)
        W_BYTE: begin
          lane_en = (lane_off == LANE_BITS'(K));
          lane_d  = src[7:0];
        end
        W_HALF: begin
          lane_en = (lane_off[LANE_BITS-1:1] == (LANE_BITS-1)'(K / 2));
          lane_d  = src[(i % 2)*8 +: 8];
        end
        W_WORD: begin
          lane_en = 1'b1;
          lane_d  = src[i*8 +: 8];
        end
        default: begin
          lane_en = 1'b0;
          lane_d  = '0;
        end
      endcase
    end

    assign be[i]          = lane_en;
    assign wdata[i*8 +: 8] = lane_d;
  end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  acc_kind_t                   kind,
  input  logic [$clog2(DATA_W/8)-1:0] lane_off,
  input  logic [DATA_W-1:0]           rdata,
  output logic [DATA_W-1:0]           value
);
  localparam int LANES     = DATA_W / 8;
  localparam int LANE_BITS = $clog2(LANES);

  logic [7:0]  sel_b;
  logic [15:0] sel_h;

  always_comb begin
    sel_b = '0;
    sel_h = '0;
    for (int k = 0; k < LANES; k++) begin
      if (lane_off == LANE_BITS'(k)) sel_b = rdata[(LANES-1-k)*8 +: 8];
    end
    for (int k = 0; k < LANES; k += 2) begin
      if (lane_off == LANE_BITS'(k)) sel_h = rdata[(LANES-2-k)*8 +: 16];
    end
  end

  always_comb begin
    unique case (kind.width)
      W_BYTE:  value = {{(DATA_W-8){kind.sext & sel_b[7]}}, sel_b};
      W_HALF:  value = {{(DATA_W-16){kind.sext & sel_h[15]}}, sel_h};
      W_WORD:  value = rdata;
      default: value = '0;
    endcase
  end

endmodule

// File: rtl/mem_lane_aligner.sv
module mem_lane_aligner
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_store,
  input  logic [2:0]          req_size,
  input  logic [ADDR_W-1:0]   req_base,
  input  logic [OFF_W-1:0]    req_offset,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [DATA_W-1:0]   rsp_data,
  output logic                rsp_err,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_rd,
  output logic                mem_we,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata
);
  localparam int LANES     = DATA_W / 8;
  localparam int LANE_BITS = $clog2(LANES);

  acc_kind_t            kind;
  logic [LANE_BITS-1:0] lane_off;
  logic                 misalign;
  logic                 bad_code;
  logic                 fault;
  logic                 accept;
  logic                 go;

  rsp_ctx_t             ctx_q;
  logic [LANE_BITS-1:0] lane_q;
  logic                 valid_q;
  logic [DATA_W-1:0]    load_val;

  lsu_addr_gen #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .LANE_BITS(LANE_BITS)
  ) u_agen (
    .base(req_base), .offset(req_offset), .size_code(req_size),
    .eff_addr(mem_addr), .kind(kind), .lane_off(lane_off),
    .misalign(misalign), .bad_code(bad_code)
  );

  lsu_store_lane #(.DATA_W(DATA_W)) u_st (
    .width(kind.width), .lane_off(lane_off), .src(req_wdata),
    .be(mem_be), .wdata(mem_wdata)
  );

  assign fault     = misalign | bad_code;
  assign req_ready = !valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign go        = accept && !fault;
  assign mem_rd    = go && !req_store;
  assign mem_we    = go && req_store;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ctx_q   <= '0;
      lane_q  <= '0;
    end else if (accept) begin
      valid_q <= 1'b1;
      ctx_q   <= '{is_load: !req_store, fault: fault, kind: kind};
      lane_q  <= lane_off;
    end else if (rsp_ready) begin
      valid_q <= 1'b0;
    end
  end

  lsu_load_extract #(.DATA_W(DATA_W)) u_ld (
    .kind(ctx_q.kind), .lane_off(lane_q), .rdata(mem_rdata), .value(load_val)
  );

  assign rsp_valid = valid_q;
  assign rsp_err   = valid_q && ctx_q.fault;
  assign rsp_data  = (valid_q && ctx_q.is_load && !ctx_q.fault) ? load_val : '0;

endmodule

// File: rtl/mem_lane_aligner_chk.sv
module mem_lane_aligner_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic [DATA_W-1:0]   rsp_data,
  input logic                rsp_err,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic                mem_rd,
  input logic                mem_we,
  input logic [DATA_W/8-1:0] mem_be
);
  localparam int LANES = DATA_W / 8;

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && (&mem_be)) |-> (mem_addr[1:0] == 2'b00)); // R2

  AST_HALF_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $countones(mem_be) == 2) |-> !mem_addr[0]); // R3

  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $countones(mem_be) == 1) |-> mem_be[LANES-1-int'(mem_addr[1:0])]); // R7

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_we)); // R10

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R10

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_data == '0)); // R10

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err))); // R11

  AST_NO_STROBE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> (!mem_rd && !mem_we)); // R11

endmodule

bind mem_lane_aligner mem_lane_aligner_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .rsp_err(rsp_err), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_we(mem_we),
  .mem_be(mem_be)
);

// File: tb/tb_mem_lane_aligner.sv
`timescale 1ns/1ps
module tb_mem_lane_aligner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_store = 1'b0;
  logic [2:0]  req_size = 3'b000;
  logic [31:0] req_base = '0;
  logic [15:0] req_offset = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic        rsp_err;
  logic [31:0] mem_addr;
  logic        mem_rd;
  logic        mem_we;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  mem_lane_aligner dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_store(req_store), .req_size(req_size), .req_base(req_base),
    .req_offset(req_offset), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_we(mem_we), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // ---------------- byte memory (big-endian within a word) ----------------
  logic [7:0] bmem [64];
  initial for (int i = 0; i < 64; i++) bmem[i] = 8'((i * 37 + 5) % 256);

  always @(posedge clk) begin
    if (mem_we)
      for (int l = 0; l < 4; l++)
        if (mem_be[l]) bmem[{mem_addr[5:2], 2'(3 - l)}] <= mem_wdata[l*8 +: 8];
    if (mem_rd)
      mem_rdata <= {bmem[{mem_addr[5:2], 2'd0}], bmem[{mem_addr[5:2], 2'd1}],
                    bmem[{mem_addr[5:2], 2'd2}], bmem[{mem_addr[5:2], 2'd3}]};
  end

  // ---------------- reference functions ----------------
  function automatic logic [31:0] ref_ea(logic [31:0] b, logic [15:0] o);
    return b + {{16{o[15]}}, o};
  endfunction

  function automatic bit ref_bad(logic [2:0] c);
    return c > 3'd4;
  endfunction

  function automatic bit ref_fault(logic [2:0] c, logic [31:0] ea);
    if (ref_bad(c)) return 1;
    if (c == 3'd0) return ea[1:0] != 2'b00;
    if (c == 3'd1 || c == 3'd2) return ea[0];
    return 0;
  endfunction

  function automatic logic [31:0] ref_load(logic [2:0] c, logic [31:0] ea);
    int a = int'(ea[5:0]);
    logic [7:0] b0 = bmem[a];
    logic [15:0] h;
    if (c == 3'd0) return {bmem[a], bmem[a+1], bmem[a+2], bmem[a+3]};
    h = {bmem[a], bmem[(a+1) % 64]};
    case (c)
      3'd1: return {{16{h[15]}}, h};
      3'd2: return {16'h0, h};
      3'd3: return {{24{b0[7]}}, b0};
      default: return {24'h0, b0};
    endcase
  endfunction

  function automatic string load_tag(logic [2:0] c);
    case (c)
      3'd0: return "R4";
      3'd1, 3'd3: return "R4,R5";
      default: return "R4,R6";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // ---------------- cycle-level response model ----------------
  bit          exp_v = 0;
  logic [31:0] exp_d = '0;
  bit          exp_e = 0;
  string       exp_dtag = "R10";
  string       exp_etag = "R10";
  bit          m_rdy;
  logic [31:0] m_ea;
  bit          m_f;

  always @(posedge clk) begin
    if (!rst_n) exp_v = 0;
    else begin
      m_rdy = !exp_v || rsp_ready;
      if (exp_v && rsp_ready) exp_v = 0;
      if (req_valid && m_rdy) begin
        m_ea  = ref_ea(req_base, req_offset);
        m_f   = ref_fault(req_size, m_ea);
        exp_v = 1;
        exp_e = m_f;
        exp_d = (m_f || req_store) ? 32'h0 : ref_load(req_size, m_ea);
        exp_dtag = (m_f || req_store) ? "R10" : load_tag(req_size);
        exp_etag = !m_f ? "R10" : ref_bad(req_size) ? "R3" : (req_size == 3'd0) ? "R2" : "R3";
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  bit          n_rdy, n_go, n_f;
  logic [31:0] n_ea, n_wd;
  logic [3:0]  n_be;
  string       n_stag;

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(!rsp_valid && !mem_rd && !mem_we, "R12",
          {29'b0, rsp_valid, mem_rd, mem_we}, 32'h0);
    end else begin
      n_rdy = !exp_v || rsp_ready;
      chk(req_ready == n_rdy, "R11", 32'(req_ready), 32'(n_rdy));
      chk(rsp_valid == exp_v, "R10", 32'(rsp_valid), 32'(exp_v));
      if (exp_v) begin
        chk(rsp_err == exp_e, exp_etag, 32'(rsp_err), 32'(exp_e));
        chk(rsp_data == exp_d, exp_dtag, rsp_data, exp_d);
      end
      n_ea = ref_ea(req_base, req_offset);
      n_f  = ref_fault(req_size, n_ea);
      n_go = req_valid && n_rdy && !n_f;
      chk(mem_rd == (n_go && !req_store),
          n_f ? (req_size == 3'd0 ? "R2" : "R3") : "R10", 32'(mem_rd), 32'(n_go && !req_store));
      chk(mem_we == (n_go && req_store),
          n_f ? (req_size == 3'd0 ? "R2" : "R3") : "R10", 32'(mem_we), 32'(n_go && req_store));
      if (n_go) begin
        chk(mem_addr == n_ea, "R1", mem_addr, n_ea);
        if (req_store) begin
          case (req_size)
            3'd0: begin n_be = 4'b1111; n_wd = req_wdata; n_stag = "R9"; end
            3'd1, 3'd2: begin
              n_be = n_ea[1] ? 4'b0011 : 4'b1100;
              n_wd = {2{req_wdata[15:0]}}; n_stag = "R8";
            end
            default: begin
              n_be = 4'b1000 >> n_ea[1:0];
              n_wd = {4{req_wdata[7:0]}}; n_stag = "R7";
            end
          endcase
          chk(mem_be == n_be, n_stag, 32'(mem_be), 32'(n_be));
          chk(mem_wdata == n_wd, n_stag, mem_wdata, n_wd);
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  // called just after a rising edge; returns just after the accepting edge
  task automatic op(bit st, logic [2:0] code, logic [31:0] b, logic [15:0] o, logic [31:0] wd);
    bit acc;
    req_valid = 1; req_store = st; req_size = code;
    req_base = b; req_offset = o; req_wdata = wd;
    do begin
      @(negedge clk); acc = req_ready;
      @(posedge clk); #2;
    end while (!acc);
    req_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 5000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    // word stores, one through a wrapping negative offset (R1, R9)
    op(1, 3'd0, 32'h0000_0010, 16'h0000, 32'h80FF_7F01);
    op(1, 3'd0, 32'h1000_0020, 16'hFFF4, 32'h1234_5678);
    idle(1);
    // R4 word load, then every byte lane signed and unsigned (R5, R6)
    op(0, 3'd0, 32'h0000_0010, 16'h0000, '0);
    for (int k = 0; k < 4; k++) begin
      op(0, 3'd3, 32'h0000_0010, 16'(k), '0);
      op(0, 3'd4, 32'h0000_0010, 16'(k), '0);
    end
    // halfwords at both offsets (R4, R5, R6)
    op(0, 3'd1, 32'h0000_0010, 16'h0000, '0);
    op(0, 3'd2, 32'h0000_0010, 16'h0000, '0);
    op(0, 3'd1, 32'h0000_0012, 16'h0000, '0);
    op(0, 3'd2, 32'h0000_0012, 16'h0000, '0);
    // sub-word stores, only low part of source used (R7, R8)
    op(1, 3'd3, 32'h0000_0014, 16'h0001, 32'hDEAD_BEAB);
    op(1, 3'd4, 32'h0000_0018, 16'h0003, 32'hFFFF_FF80);
    op(1, 3'd1, 32'h0000_0014, 16'h0002, 32'hCAFE_9A7F);
    op(1, 3'd2, 32'h0000_0018, 16'h0000, 32'h0000_8001);
    op(0, 3'd0, 32'h0000_0014, 16'h0000, '0);
    op(0, 3'd0, 32'h0000_0018, 16'h0000, '0);
    // misaligned and undefined codes (R2, R3)
    op(0, 3'd0, 32'h0000_0011, 16'h0000, '0);
    op(1, 3'd0, 32'h0000_0010, 16'h0002, 32'hFFFF_FFFF);
    op(0, 3'd1, 32'h0000_0013, 16'h0000, '0);
    op(1, 3'd2, 32'h0000_0010, 16'h0001, 32'hFFFF_FFFF);
    op(0, 3'd5, 32'h0000_0010, 16'h0000, '0);
    op(1, 3'd7, 32'h0000_0010, 16'h0000, 32'hFFFF_FFFF);
    op(0, 3'd0, 32'h0000_0010, 16'h0000, '0); // unchanged after faulty stores
    idle(1);
    // response back-pressure (R11)
    rsp_ready = 0;
    fork
      begin
        op(0, 3'd3, 32'h0000_0010, 16'h0003, '0);
        op(0, 3'd4, 32'h0000_0014, 16'h0002, '0);
      end
      begin idle(4); rsp_ready = 1; end
    join
    idle(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule